// File: doc/BRIEF.md
# Fixed-Rate Virtual Output Queue Buffer

This block is the buffering middle stage of a two-stage load-balanced packet switch. Each clock cycle is one slot. In a slot the first-stage fabric may hand it one cell, tagged with the output port the cell must finally leave on. The cell is filed into the per-output FIFO for that port, whatever port it came in on. The block holds one FIFO for each output of the switch.

The read side does not look at how full the queues are. A free-running slot counter picks one queue per slot in a fixed rotation, so every queue gets exactly one slot in N. The rotation is offset by this buffer's own position in the switch. If the chosen queue is empty, the slot is lost, even when other queues hold cells. A queue that is full drops an arriving cell and latches a per-queue overflow flag. The occupancy of every queue can be read at all times.

Top module: `voq_buffer`

## Requirements
- R1: After reset every queue level is 0, every overflow flag is 0, `outValid` is 0 and `slotNow` is 0.
- R2: A cell with `inValid` high and `inDest` = p, where 1 <= p <= NUM_PORTS, is written into queue p. The level of queue p, at bits [(p-1)*CNT_W +: CNT_W] of `queueLevel`, goes up by one in the next cycle, less any dequeue from queue p in the same slot.
- R3: Queue p is full when its level equals DEPTH at the start of a slot. A cell for a full queue is dropped, even if queue p is also served in that slot, and bit p-1 of `overflowFlag` is set. Once set, that bit stays set until reset.
- R4: `slotNow` goes up by one each clock cycle and wraps from NUM_PORTS-1 to 0.
- R5: In slot t (the value of `slotNow` before the edge) the queue served is ((BUF_ID + t) mod NUM_PORTS) + 1. If that queue holds a cell, its oldest cell appears in the next cycle with `outValid` high and `outDest` equal to that port number.
- R6: If the queue due in a slot is empty, `outValid` is low in the next cycle and no other queue gives up a cell.
- R7: Within one queue, cells leave in the order they arrived.
- R8: An enqueue into a non-full queue and a dequeue from that same queue in the same slot both take effect, and the level of that queue does not change.
- R9: A cell with `inDest` equal to 0 or greater than NUM_PORTS is ignored. No level changes and no overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A cell is offered in this slot |
| inData | input | DATA_W | Cell payload |
| inDest | input | PORT_W | Final output port of the cell, 1-based |
| outValid | output | 1 | A cell is presented on the output |
| outData | output | DATA_W | Payload of the cell presented |
| outDest | output | PORT_W | Output port of the queue served, 1-based |
| slotNow | output | QIDX_W | Current slot number, 0 to NUM_PORTS-1 |
| queueLevel | output | NUM_PORTS*CNT_W | Level of every queue, queue p in slice p-1 |
| overflowFlag | output | NUM_PORTS | Sticky drop flag, bit p-1 for queue p |

## Verification
The assertions take for granted that reset is held low for at least one edge before traffic starts. They also assume that `inDest` may take any value, including out-of-range codes, because the control logic filters those codes before any strobe reaches the storage. The stimulus keeps one cell per slot at most. The random phase draws destinations from 0 to NUM_PORTS+1 on purpose, so that invalid codes appear. Directed bursts toward a single port push one queue past DEPTH, and directed cells are timed to land in the slot where their own queue is being served.

// File: rtl/voq_pkg.sv
package voq_pkg;
  // strobes from the control half to the storage half, one slot at a time
  typedef struct packed {
    logic enqEn;   // write the incoming cell into the selected queue
    logic deqEn;   // pop the head of the selected queue onto the output
  } voqStrobes_t;
endpackage

// File: rtl/voq_ctrl.sv
module voq_ctrl #(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 4,
  parameter int BUF_ID    = 1,
  localparam int QIDX_W   = $clog2(NUM_PORTS),
  localparam int PORT_W   = $clog2(NUM_PORTS + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 inValid,
  input  logic [PORT_W-1:0]                    inDest,
  input  logic [NUM_PORTS-1:0][CNT_W-1:0]      levelQ,
  output voq_pkg::voqStrobes_t                 strb,
  output logic [QIDX_W-1:0]                    enqIdx,
  output logic [QIDX_W-1:0]                    deqIdx,
  output logic [QIDX_W-1:0]                    slotCnt,
  output logic [NUM_PORTS-1:0]                 overflowFlag
);
  localparam int BASE = BUF_ID % NUM_PORTS;

  logic             destOk;
  logic             destFull;
  logic [QIDX_W:0]  rotSum;

  // 1-based port on the wire, 0-based queue inside
  assign destOk = (inDest != '0) && (inDest <= PORT_W'(NUM_PORTS));
  assign enqIdx = QIDX_W'(inDest - PORT_W'(1));
  assign destFull = destOk && (levelQ[enqIdx] == CNT_W'(DEPTH));

  // fixed rotation: slot t serves queue (BUF_ID + t) mod N
  assign rotSum = (QIDX_W+1)'(BASE) + {1'b0, slotCnt};
  assign deqIdx = (rotSum >= (QIDX_W+1)'(NUM_PORTS))
                  ? QIDX_W'(rotSum - (QIDX_W+1)'(NUM_PORTS))
                  : QIDX_W'(rotSum);

  always_comb begin
    strb.enqEn = inValid && destOk && !destFull;
    strb.deqEn = (levelQ[deqIdx] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt      <= '0;
      overflowFlag <= '0;
    end else begin
      slotCnt <= (slotCnt == QIDX_W'(NUM_PORTS - 1)) ? '0 : slotCnt + QIDX_W'(1);
      if (inValid && destFull) overflowFlag[enqIdx] <= 1'b1;
    end
  end

  assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotCnt == QIDX_W'(NUM_PORTS - 1)) |=> (slotCnt == '0));
  assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotCnt != QIDX_W'(NUM_PORTS - 1)) |=> (slotCnt == $past(slotCnt) + QIDX_W'(1)));
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((overflowFlag & $past(overflowFlag)) == $past(overflowFlag)));
endmodule

// File: rtl/voq_store.sv
module voq_store #(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 8,
  localparam int QIDX_W   = $clog2(NUM_PORTS),
  localparam int PORT_W   = $clog2(NUM_PORTS + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  voq_pkg::voqStrobes_t            strb,
  input  logic [QIDX_W-1:0]               enqIdx,
  input  logic [QIDX_W-1:0]               deqIdx,
  input  logic [DATA_W-1:0]               wrData,
  output logic [NUM_PORTS-1:0][CNT_W-1:0] levelQ,
  output logic                            outValid,
  output logic [DATA_W-1:0]               outData,
  output logic [PORT_W-1:0]               outDest
);
  logic [DATA_W-1:0] mem [NUM_PORTS][DEPTH];
  logic [PTR_W-1:0]  wrPtr [NUM_PORTS];
  logic [PTR_W-1:0]  rdPtr [NUM_PORTS];

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_queue
    logic pushK, popK;
    assign pushK = strb.enqEn && (enqIdx == QIDX_W'(k));
    assign popK  = strb.deqEn && (deqIdx == QIDX_W'(k));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        levelQ[k] <= '0;
        wrPtr[k]  <= '0;
        rdPtr[k]  <= '0;
      end else begin
        levelQ[k] <= levelQ[k] + CNT_W'(pushK) - CNT_W'(popK);
        if (pushK) wrPtr[k] <= (wrPtr[k] == PTR_W'(DEPTH - 1)) ? '0 : wrPtr[k] + PTR_W'(1);
        if (popK)  rdPtr[k] <= (rdPtr[k] == PTR_W'(DEPTH - 1)) ? '0 : rdPtr[k] + PTR_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (pushK) mem[k][wrPtr[k]] <= wrData;
    end

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
      levelQ[k] <= CNT_W'(DEPTH));
    assert_same_slot_R8: assert property (@(posedge clk) disable iff (!rstN)
      (pushK && popK) |=> $stable(levelQ[k]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outDest  <= '0;
    end else begin
      outValid <= strb.deqEn;
      if (strb.deqEn) begin
        outData <= mem[deqIdx][rdPtr[deqIdx]];
        outDest <= PORT_W'(deqIdx) + PORT_W'(1);
      end
    end
  end

  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.deqEn |-> (levelQ[deqIdx] != '0));
  assert_idle_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.deqEn |=> !outValid);
endmodule

// File: rtl/voq_buffer.sv
module voq_buffer #(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 8,
  parameter int BUF_ID    = 1,
  localparam int QIDX_W   = $clog2(NUM_PORTS),
  localparam int PORT_W   = $clog2(NUM_PORTS + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [DATA_W-1:0]            inData,
  input  logic [PORT_W-1:0]            inDest,
  output logic                         outValid,
  output logic [DATA_W-1:0]            outData,
  output logic [PORT_W-1:0]            outDest,
  output logic [QIDX_W-1:0]            slotNow,
  output logic [NUM_PORTS*CNT_W-1:0]   queueLevel,
  output logic [NUM_PORTS-1:0]         overflowFlag
);
  voq_pkg::voqStrobes_t             strb;
  logic [QIDX_W-1:0]                enqIdx, deqIdx;
  logic [NUM_PORTS-1:0][CNT_W-1:0]  levelQ;

  voq_ctrl #(.NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH), .BUF_ID(BUF_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest),
    .levelQ(levelQ), .strb(strb), .enqIdx(enqIdx), .deqIdx(deqIdx),
    .slotCnt(slotNow), .overflowFlag(overflowFlag));

  voq_store #(.NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .enqIdx(enqIdx), .deqIdx(deqIdx),
    .wrData(inData), .levelQ(levelQ), .outValid(outValid),
    .outData(outData), .outDest(outDest));

  assign queueLevel = levelQ;
endmodule

// File: tb/sim_voq_buffer.sv
module sim_voq_buffer;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int DW = 8;
  localparam int ID = 2;
  localparam int PW = $clog2(N + 1);
  localparam int QW = $clog2(N);
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [PW-1:0] inDest = '0;
  logic outValid;
  logic [DW-1:0] outData;
  logic [PW-1:0] outDest;
  logic [QW-1:0] slotNow;
  logic [N*CW-1:0] queueLevel;
  logic [N-1:0] overflowFlag;

  voq_buffer #(.NUM_PORTS(N), .DEPTH(D), .DATA_W(DW), .BUF_ID(ID)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inDest(inDest),
    .outValid(outValid), .outData(outData), .outDest(outDest), .slotNow(slotNow),
    .queueLevel(queueLevel), .overflowFlag(overflowFlag));

  always #4 clk = ~clk;  // 125 MHz

  int total = 0;
  int bad = 0;

  // bench reference state
  int mq [N][D];
  int mcnt [N];
  int mslot = 0;
  int movf = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int servedPort(input int t);
    return ((ID + t) % N) + 1;
  endfunction

  function automatic int levelOf(input int q);
    return int'(queueLevel[q*CW +: CW]);
  endfunction

  // one slot: drive at negedge, update the reference, compare at next negedge
  task automatic step(input bit v, input int dest, input int data, input string tag);
    int q, pre, expData;
    bit expV;
    inValid = v;
    inDest  = PW'(dest);
    inData  = DW'(data);
    q = servedPort(mslot) - 1;
    pre = (dest >= 1 && dest <= N) ? mcnt[dest-1] : 0;
    expV = (mcnt[q] > 0);
    expData = 0;
    if (expV) begin
      expData = mq[q][0];
      for (int i = 0; i < D - 1; i++) mq[q][i] = mq[q][i+1];
      mcnt[q]--;
    end
    if (v && dest >= 1 && dest <= N) begin
      if (pre >= D) movf = movf | (1 << (dest - 1));
      else begin
        mq[dest-1][mcnt[dest-1]] = data;
        mcnt[dest-1]++;
      end
    end
    mslot = (mslot + 1) % N;
    @(posedge clk);
    @(negedge clk);
    check(outValid == expV, expV ? "R5 valid" : "R6 idle", int'(outValid), int'(expV));
    if (expV) begin
      check(int'(outDest) == q + 1, "R5 dest", int'(outDest), q + 1);
      check(int'(outData) == expData, "R7 order", int'(outData), expData);
    end
    for (int k = 0; k < N; k++)
      check(levelOf(k) == mcnt[k], tag, levelOf(k), mcnt[k]);
    check(int'(overflowFlag) == movf, "R3 flag", int'(overflowFlag), movf);
    check(int'(slotNow) == mslot, "R4 slot", int'(slotNow), mslot);
    inValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int k = 0; k < N; k++) mcnt[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1 valid", int'(outValid), 0);
    check(queueLevel == '0, "R1 level", int'(queueLevel), 0);
    check(overflowFlag == '0, "R1 flag", int'(overflowFlag), 0);
    check(slotNow == '0, "R1 slot", int'(slotNow), 0);
    rstN = 1'b1;

    // R2 one cell to each port
    for (int p = 1; p <= N; p++) step(1'b1, p, 16 + p, "R2 level");
    for (int i = 0; i < N; i++) step(1'b0, 0, 0, "R2 level");

    // R3 burst toward port 1 past its depth
    for (int i = 0; i < D + 3; i++) step(1'b1, 1, 64 + i, "R3 level");
    check(overflowFlag[0] == 1'b1, "R3 set", int'(overflowFlag[0]), 1);
    for (int i = 0; i < 2 * N; i++) step(1'b0, 0, 0, "R3 level");
    check(overflowFlag[0] == 1'b1, "R3 held", int'(overflowFlag[0]), 1);

    // R9 out-of-range destinations
    step(1'b1, 0, 200, "R9 level");
    step(1'b1, N + 1, 201, "R9 level");
    step(1'b1, (1 << PW) - 1, 202, "R9 level");

    // R8 push into the queue being served while it holds cells
    for (int p = 1; p <= N; p++) begin
      step(1'b1, p, 100 + p, "R8 level");
      step(1'b1, p, 110 + p, "R8 level");
    end
    for (int i = 0; i < 2 * N; i++) step(1'b1, servedPort(mslot), 120 + i, "R8 level");

    // R6 drain, then empty slots
    for (int i = 0; i < 4 * N * D; i++) step(1'b0, 0, 0, "R6 level");
    for (int i = 0; i < N; i++) step(1'b0, 0, 0, "R6 level");

    // random traffic, destinations include invalid codes
    for (int i = 0; i < 600; i++) begin
      bit v;
      int dst;
      v = ($urandom % 10) < 7;
      dst = int'($urandom % (N + 2));
      step(v, dst, int'($urandom % 256), "R2 level");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule